// File: doc/BRIEF.md
# Square-Wave NCO Clock Synthesizer

This block turns a phase accumulator into a trapezoidal square wave, one signed 16-bit sample per accepted output beat, so that a DAC can synthesize a clock. The output frequency, phase offset and amplitude come from live inputs. Each edge has a linear ramp whose length is a power-of-two fraction of the period, so the ramp scales with frequency. The high time is set by a 12-bit duty code. The slew and duty settings sit in shadow registers and take effect only on a trigger strobe. A gate input forces the waveform to its low level instead of mid-code.

The sample stream leaves through a valid/ready pair. The pipeline advances when `out_ready` is high or when `out_valid` is low. On a stalled beat (`out_valid` high, `out_ready` low) the accumulator, both pipeline stages and the presented sample all hold, and no sample is dropped or repeated. Two sticky-style status pins report an over-range tuning word and a clamped duty code.

Top module: `sqw_nco_synth`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `sample_out`, `freq_err` and `duty_clamped` are 0. The accumulator restarts at 0, the active slew code at 0 and the active duty code at 2048.
- R2: Every pipeline advance adds `ftw` to a 64-bit accumulator A that wraps. The shaping phase p is the upper 32 bits of A plus `phase_ofs`, modulo 2^32. The value of A before an advance reaches `sample_out` after two advances, and `out_valid` rises on the second advance after reset.
- R3: With active slew S and active duty code C, let s = 2^(30-S) and D = C·2^20. The raw sample is ((p<<S)>>14) − 32768 for p < s, 32767 for s ≤ p < D, 32767 − (((p−D)<<S)>>14) for D ≤ p < D+s, and −32768 otherwise.
- R4: A slew code above 9 is used as 9.
- R5: `sample_out` equals (raw × `amp`) arithmetically shifted right by 15, saturated to 32767. With `amp` = 32767 the output spans −32767 to 32766. With `amp` = 0 it is constantly 0. `amp` is applied on the second stage.
- R6: When `gate_en` is low at an advance, that stage-one sample is −32768, so the output is the scaled minimum (−32767 for `amp` = 32767).
- R7: `slew_code` and `duty_code` are copied into the active settings only on a clock edge with `trig` high. The copy is used from the next advance onward, and changes without a trigger have no effect on the output.
- R8: `freq_err` becomes 1 on the edge after `ftw` exceeds 2^62, and stays 1 until reset.
- R9: On a trigger, a duty code below 1024·2^-S is replaced by 1024·2^-S, and one above 4096 − 1024·2^-S is replaced by that bound (S after R4). `duty_clamped` is then 1, and a later trigger with an in-range code returns it to 0.
- R10: When `out_valid` is high and `out_ready` is low, `sample_out` and `out_valid` hold on the next edge and the accumulator does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ftw | input | 64 | Frequency tuning word added per advance |
| phase_ofs | input | 32 | Phase offset added to the upper accumulator bits |
| amp | input | 16 | Signed amplitude multiplier |
| slew_code | input | 4 | Edge ramp code, shadowed until trigger |
| duty_code | input | 12 | Duty code (4096 = full period), shadowed until trigger |
| trig | input | 1 | Loads the shadowed slew and duty settings |
| gate_en | input | 1 | Low forces the low level |
| out_ready | input | 1 | Downstream accepts the sample |
| out_valid | output | 1 | Sample is valid |
| sample_out | output | 16 | Signed output sample |
| freq_err | output | 1 | Sticky: tuning word above a quarter of the rate |
| duty_clamped | output | 1 | Last trigger clamped the duty code |

## Verification
A 1024-sample period with a quarter-period offset separates the four waveform regions and shows whether the offset is applied. Full, zero and most-negative amplitudes tell scaling apart from saturation and from gating. A slow ramp at slew code 15 is reached by jumping the phase offset near the wrap point and near the duty edge, which exposes a wrong shift or a missing saturation of the code. Out-of-range duty codes at both ends, tuning words on either side of the limit, and random back-pressure mixed with random settings check clamping, the sticky flag and beat holding against a cycle model in the bench.

// File: rtl/sqw_pkg.sv
package sqw_pkg;
  localparam int ACC_W    = 64;
  localparam int PH_W     = 32;
  localparam int SMP_W    = 16;
  localparam int DUTY_W   = 12;
  localparam int SLEW_W   = 4;
  localparam int SLEW_MAX = 9;
endpackage

// File: rtl/sqw_phase_acc.sv
module sqw_phase_acc #(
  parameter int ACC_W = sqw_pkg::ACC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [ACC_W-1:0] ftw,
  output logic [ACC_W-1:0] acc_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   acc_q <= '0;
    else if (adv) acc_q <= acc_q + ftw;
  end
endmodule

// File: rtl/sqw_shaper.sv
module sqw_shaper #(
  parameter int PH_W     = sqw_pkg::PH_W,
  parameter int SMP_W    = sqw_pkg::SMP_W,
  parameter int DUTY_W   = sqw_pkg::DUTY_W,
  parameter int SLEW_W   = sqw_pkg::SLEW_W,
  parameter int SLEW_MAX = sqw_pkg::SLEW_MAX
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    adv,
  input  logic                    trig,
  input  logic [SLEW_W-1:0]       slew_in,
  input  logic [DUTY_W-1:0]       duty_in,
  input  logic                    gate_en,
  input  logic [PH_W-1:0]         phase,
  output logic signed [SMP_W-1:0] raw_q,
  output logic                    raw_vld,
  output logic [SLEW_W-1:0]       act_slew,
  output logic [DUTY_W-1:0]       act_duty,
  output logic                    duty_clamped
);
  localparam int CW   = DUTY_W + 1;
  localparam int DSH  = PH_W - DUTY_W;
  localparam int RSH0 = PH_W - 2 - SMP_W;
  localparam logic [CW-1:0] QTR  = CW'(1) << (DUTY_W - 2);
  localparam logic [CW-1:0] FULL = CW'(1) << DUTY_W;
  localparam logic [DUTY_W-1:0] HALF = DUTY_W'(FULL >> 1);
  localparam logic signed [SMP_W-1:0] S_MAX = {1'b0, {(SMP_W-1){1'b1}}};
  localparam logic signed [SMP_W-1:0] S_MIN = {1'b1, {(SMP_W-1){1'b0}}};

  // trigger-side legalisation of the shadowed settings
  logic [SLEW_W-1:0] slew_sat;
  logic [CW-1:0]     lo_b, hi_b;
  logic [DUTY_W-1:0] duty_fix;
  logic              oob;

  always_comb begin
    slew_sat = (slew_in > SLEW_W'(SLEW_MAX)) ? SLEW_W'(SLEW_MAX) : slew_in;
    lo_b     = QTR >> slew_sat;
    hi_b     = FULL - lo_b;
    oob      = 1'b0;
    duty_fix = duty_in;
    if ({1'b0, duty_in} < lo_b) begin
      duty_fix = lo_b[DUTY_W-1:0];
      oob      = 1'b1;
    end else if ({1'b0, duty_in} > hi_b) begin
      duty_fix = hi_b[DUTY_W-1:0];
      oob      = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_slew     <= '0;
      act_duty     <= HALF;
      duty_clamped <= 1'b0;
    end else if (trig) begin
      act_slew     <= slew_sat;
      act_duty     <= duty_fix;
      duty_clamped <= oob;
    end
  end

  // region decode and ramp by shift
  logic [PH_W:0]           p_x, s_len, d_ph, d_end, q_x;
  logic [SMP_W-1:0]        up_r, dn_r;
  logic signed [SMP_W-1:0] shaped;

  always_comb begin
    p_x   = {1'b0, phase};
    s_len = ((PH_W+1)'(1) << (PH_W - 2)) >> act_slew;
    d_ph  = {1'b0, act_duty, {DSH{1'b0}}};
    d_end = d_ph + s_len;
    q_x   = p_x - d_ph;
    up_r  = SMP_W'((p_x << act_slew) >> RSH0);
    dn_r  = SMP_W'((q_x << act_slew) >> RSH0);
    if (p_x < s_len)      shaped = {~up_r[SMP_W-1], up_r[SMP_W-2:0]};
    else if (p_x < d_ph)  shaped = S_MAX;
    else if (p_x < d_end) shaped = ~{~dn_r[SMP_W-1], dn_r[SMP_W-2:0]};
    else                  shaped = S_MIN;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q   <= '0;
      raw_vld <= 1'b0;
    end else if (adv) begin
      raw_q   <= gate_en ? shaped : S_MIN;
      raw_vld <= 1'b1;
    end
  end
endmodule

// File: rtl/sqw_scaler.sv
module sqw_scaler #(
  parameter int SMP_W = sqw_pkg::SMP_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    adv,
  input  logic signed [SMP_W-1:0] raw_in,
  input  logic                    raw_vld,
  input  logic signed [SMP_W-1:0] amp,
  output logic signed [SMP_W-1:0] out_q,
  output logic                    out_vld
);
  localparam int PW = 2 * SMP_W;
  localparam logic signed [SMP_W-1:0] S_MAX = {1'b0, {(SMP_W-1){1'b1}}};

  logic signed [PW-1:0]    prod, shd;
  logic                    ovf;
  logic signed [SMP_W-1:0] sat;

  always_comb begin
    prod = raw_in * amp;
    shd  = prod >>> (SMP_W - 1);
    ovf  = ~shd[PW-1] & (|shd[PW-2:SMP_W-1]);
    sat  = ovf ? S_MAX : shd[SMP_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q   <= '0;
      out_vld <= 1'b0;
    end else if (adv) begin
      out_q   <= sat;
      out_vld <= raw_vld;
    end
  end
endmodule

// File: rtl/sqw_nco_synth.sv
module sqw_nco_synth #(
  parameter int ACC_W    = sqw_pkg::ACC_W,
  parameter int PH_W     = sqw_pkg::PH_W,
  parameter int SMP_W    = sqw_pkg::SMP_W,
  parameter int DUTY_W   = sqw_pkg::DUTY_W,
  parameter int SLEW_W   = sqw_pkg::SLEW_W,
  parameter int SLEW_MAX = sqw_pkg::SLEW_MAX
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ACC_W-1:0]        ftw,
  input  logic [PH_W-1:0]         phase_ofs,
  input  logic signed [SMP_W-1:0] amp,
  input  logic [SLEW_W-1:0]       slew_code,
  input  logic [DUTY_W-1:0]       duty_code,
  input  logic                    trig,
  input  logic                    gate_en,
  input  logic                    out_ready,
  output logic                    out_valid,
  output logic signed [SMP_W-1:0] sample_out,
  output logic                    freq_err,
  output logic                    duty_clamped
);
  localparam logic [ACC_W-1:0] FREQ_LIM = ACC_W'(1) << (ACC_W - 2);

  logic                    adv;
  logic [ACC_W-1:0]        acc_q;
  logic [PH_W-1:0]         phase;
  logic signed [SMP_W-1:0] raw_q;
  logic                    raw_vld;
  logic [SLEW_W-1:0]       act_slew;
  logic [DUTY_W-1:0]       act_duty;

  assign adv   = out_ready | ~out_valid;
  assign phase = acc_q[ACC_W-1 -: PH_W] + phase_ofs;

  sqw_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .adv(adv), .ftw(ftw), .acc_q(acc_q)
  );

  sqw_shaper #(
    .PH_W(PH_W), .SMP_W(SMP_W), .DUTY_W(DUTY_W),
    .SLEW_W(SLEW_W), .SLEW_MAX(SLEW_MAX)
  ) u_shape (
    .clk(clk), .rst_n(rst_n), .adv(adv), .trig(trig),
    .slew_in(slew_code), .duty_in(duty_code), .gate_en(gate_en),
    .phase(phase), .raw_q(raw_q), .raw_vld(raw_vld),
    .act_slew(act_slew), .act_duty(act_duty), .duty_clamped(duty_clamped)
  );

  sqw_scaler #(.SMP_W(SMP_W)) u_scale (
    .clk(clk), .rst_n(rst_n), .adv(adv), .raw_in(raw_q), .raw_vld(raw_vld),
    .amp(amp), .out_q(sample_out), .out_vld(out_valid)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)               freq_err <= 1'b0;
    else if (ftw > FREQ_LIM)  freq_err <= 1'b1;
  end
endmodule

// File: rtl/sqw_nco_synth_chk.sv
module sqw_nco_synth_chk #(
  parameter int ACC_W    = sqw_pkg::ACC_W,
  parameter int SMP_W    = sqw_pkg::SMP_W,
  parameter int DUTY_W   = sqw_pkg::DUTY_W,
  parameter int SLEW_W   = sqw_pkg::SLEW_W,
  parameter int SLEW_MAX = sqw_pkg::SLEW_MAX
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ACC_W-1:0]  ftw,
  input logic              trig,
  input logic              out_ready,
  input logic              out_valid,
  input logic [SMP_W-1:0]  sample_out,
  input logic              freq_err,
  input logic [SLEW_W-1:0] act_slew,
  input logic [DUTY_W-1:0] act_duty
);
  localparam logic [ACC_W-1:0] LIM = ACC_W'(1) << (ACC_W - 2);
  localparam int CW = DUTY_W + 1;
  localparam logic [CW-1:0] QTR  = CW'(1) << (DUTY_W - 2);
  localparam logic [CW-1:0] FULL = CW'(1) << DUTY_W;

  logic [CW-1:0] lo_c, hi_c;
  assign lo_c = QTR >> act_slew;
  assign hi_c = FULL - lo_c;

  a_r8_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ftw > LIM) |=> freq_err);

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    freq_err |=> freq_err);

  a_r7_shadow_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !trig |=> ($stable(act_slew) && $stable(act_duty)));

  a_r4_slew_limit: assert property (@(posedge clk) disable iff (!rst_n)
    act_slew <= SLEW_W'(SLEW_MAX));

  a_r9_duty_legal: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, act_duty} >= lo_c) && ({1'b0, act_duty} <= hi_c));

  a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(sample_out)));
endmodule

bind sqw_nco_synth sqw_nco_synth_chk #(
  .ACC_W(ACC_W), .SMP_W(SMP_W), .DUTY_W(DUTY_W),
  .SLEW_W(SLEW_W), .SLEW_MAX(SLEW_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ftw(ftw), .trig(trig),
  .out_ready(out_ready), .out_valid(out_valid), .sample_out(sample_out),
  .freq_err(freq_err), .act_slew(act_slew), .act_duty(act_duty)
);

// File: tb/tb_sqw_nco_synth.sv
module tb_sqw_nco_synth;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [63:0]        ftw = '0;
  logic [31:0]        phase_ofs = '0;
  logic signed [15:0] amp = 16'sd32767;
  logic [3:0]         slew_code = '0;
  logic [11:0]        duty_code = 12'd2048;
  logic               trig = 1'b0;
  logic               gate_en = 1'b1;
  logic               out_ready = 1'b1;
  logic               out_valid;
  logic signed [15:0] sample_out;
  logic               freq_err;
  logic               duty_clamped;

  sqw_nco_synth dut (
    .clk(clk), .rst_n(rst_n), .ftw(ftw), .phase_ofs(phase_ofs), .amp(amp),
    .slew_code(slew_code), .duty_code(duty_code), .trig(trig),
    .gate_en(gate_en), .out_ready(out_ready), .out_valid(out_valid),
    .sample_out(sample_out), .freq_err(freq_err), .duty_clamped(duty_clamped)
  );

  always #5 clk = ~clk;

  int    n_vec = 0;
  int    n_bad = 0;
  bit    finished = 1'b0;
  string tag = "R1";

  // cycle model state
  logic [63:0] m_acc;
  longint      m_raw, m_out;
  bit          m_v1, m_v2, m_err, m_clamp;
  int          m_slew, m_duty;
  longint      seen_min, seen_max;

  task automatic chk(string r, string what, longint act, longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  function automatic longint ref_raw(logic [63:0] acc, logic [31:0] ofs, int s, int d);
    longint p, sl, dp;
    p  = longint'(32'(acc[63:32] + ofs));
    sl = 64'sd1 <<< (30 - s);
    dp = longint'(d) <<< 20;
    if (p < sl)           return ((p <<< s) >>> 14) - 32768;
    else if (p < dp)      return 32767;
    else if (p < dp + sl) return 32767 - (((p - dp) <<< s) >>> 14);
    else                  return -32768;
  endfunction

  function automatic longint ref_scale(longint raw, longint a);
    longint v;
    v = (raw * a) >>> 15;
    if (v > 32767) v = 32767;
    return v;
  endfunction

  task automatic model_reset();
    m_acc = '0; m_raw = 0; m_out = 0; m_v1 = 0; m_v2 = 0;
    m_err = 0; m_clamp = 0; m_slew = 0; m_duty = 2048;
  endtask

  task automatic cyc();
    bit adv;
    logic [63:0] n_acc;
    longint n_raw, n_out;
    bit n_v1, n_v2, n_clamp;
    int n_slew, n_duty, lo, hi;
    adv = out_ready || !m_v2;
    n_acc = m_acc; n_raw = m_raw; n_out = m_out; n_v1 = m_v1; n_v2 = m_v2;
    if (adv) begin
      n_raw = gate_en ? ref_raw(m_acc, phase_ofs, m_slew, m_duty) : -32768;
      n_out = ref_scale(m_raw, longint'(amp));
      n_v1 = 1; n_v2 = m_v1;
      n_acc = m_acc + ftw;
    end
    n_slew = m_slew; n_duty = m_duty; n_clamp = m_clamp;
    if (trig) begin
      n_slew = (slew_code > 9) ? 9 : int'(slew_code);
      lo = 1024 >> n_slew; hi = 4096 - lo;
      n_duty = int'(duty_code); n_clamp = 0;
      if (n_duty < lo) begin n_duty = lo; n_clamp = 1; end
      else if (n_duty > hi) begin n_duty = hi; n_clamp = 1; end
    end
    @(posedge clk);
    m_acc = n_acc; m_raw = n_raw; m_out = n_out; m_v1 = n_v1; m_v2 = n_v2;
    m_slew = n_slew; m_duty = n_duty; m_clamp = n_clamp;
    if (ftw > (64'd1 << 62)) m_err = 1;
    @(negedge clk);
    chk(tag, "out_valid", longint'(out_valid), longint'(m_v2));
    if (m_v2) begin
      chk(tag, "sample_out", longint'(sample_out), m_out);
      if (longint'(sample_out) < seen_min) seen_min = longint'(sample_out);
      if (longint'(sample_out) > seen_max) seen_max = longint'(sample_out);
    end
    chk(tag, "freq_err", longint'(freq_err), longint'(m_err));
    chk(tag, "duty_clamped", longint'(duty_clamped), longint'(m_clamp));
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic pulse_trig();
    trig = 1'b1; cyc(); trig = 1'b0;
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_up();
  end

  initial begin
    void'($urandom(32'd2718));
    model_reset();
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "out_valid", longint'(out_valid), 0);
    chk("R1", "sample_out", longint'(sample_out), 0);
    chk("R1", "freq_err", longint'(freq_err), 0);
    chk("R1", "duty_clamped", longint'(duty_clamped), 0);
    rst_n = 1'b1;

    // R3: 1024-sample period, default 50 % duty, slew 0
    tag = "R3"; ftw = 64'd1 << 54; run(2100);
    // R2: quarter-period phase offset
    tag = "R2"; phase_ofs = 32'h4000_0000; run(1100); phase_ofs = '0;

    // R5: full amplitude range, zero amplitude, saturation
    tag = "R5"; seen_min = 99999; seen_max = -99999; run(1100);
    chk("R5", "min of span", seen_min, -32767);
    chk("R5", "max of span", seen_max, 32766);
    amp = 16'sd0; run(3);
    chk("R5", "zero amp sample", longint'(sample_out), 0);
    run(300);
    amp = -16'sd32768; run(1100);
    amp = 16'sd32767;

    // R6: gate holds the scaled low level
    tag = "R6"; gate_en = 1'b0; run(200);
    chk("R6", "gated sample", longint'(sample_out), -32767);
    run(100); gate_en = 1'b1;

    // R7: changes without trigger are ignored, then take effect
    tag = "R7"; slew_code = 4'd2; duty_code = 12'd3000; run(1100);
    pulse_trig(); run(1100);

    // R4: slew code 15 treated as 9, slow ramp reached by phase jumps
    tag = "R4"; slew_code = 4'd15; duty_code = 12'd2000; pulse_trig();
    ftw = 64'd1 << 49;
    phase_ofs = 32'(-(m_acc[63:32]) - 32'h0010_0000); run(60);
    phase_ofs = 32'(-(m_acc[63:32]) + (32'd2000 << 20) - 32'h0010_0000); run(60);
    phase_ofs = '0; ftw = 64'd1 << 54;

    // R9: clamping at both ends, then recovery
    tag = "R9"; slew_code = 4'd0; duty_code = 12'd10; pulse_trig();
    chk("R9", "low clamp flag", longint'(duty_clamped), 1);
    run(1100);
    duty_code = 12'd4095; pulse_trig(); run(1100);
    duty_code = 12'd2048; pulse_trig();
    chk("R9", "flag clears", longint'(duty_clamped), 0);
    run(50);

    // R8: tuning word limit
    tag = "R8"; ftw = 64'd1 << 62; run(2);
    chk("R8", "at limit", longint'(freq_err), 0);
    ftw = (64'd1 << 62) + 64'd1; run(1);
    chk("R8", "above limit", longint'(freq_err), 1);
    ftw = 64'd1 << 54; run(20);
    chk("R8", "sticky", longint'(freq_err), 1);

    // R10: random back-pressure
    tag = "R10";
    for (int i = 0; i < 2000; i++) begin
      out_ready = ($urandom % 2) == 0; cyc();
    end
    out_ready = 1'b1;

    // mixed random settings
    tag = "R3";
    for (int i = 0; i < 20000; i++) begin
      out_ready = ($urandom % 5) != 0;
      if ($urandom % 400 == 0) ftw = {6'b0, 26'($urandom), $urandom};
      if ($urandom % 300 == 0) phase_ofs = $urandom;
      if ($urandom % 300 == 0) amp = 16'($urandom);
      if ($urandom % 200 == 0) gate_en = ($urandom % 4) != 0;
      slew_code = 4'($urandom % 12);
      duty_code = 12'($urandom);
      trig = ($urandom % 250) == 0;
      cyc();
    end
    trig = 1'b0;
    finish_up();
  end
endmodule